// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell Unit

This unit holds one 32-bit doorbell word for each processor core, used to raise inter-processor interrupts. Any core may post message bits into any other core's doorbell. The receiving core reads its doorbell and acknowledges the bits it has handled. Every core also owns an enable flag. A doorbell that holds any bit, with its owner's enable set, drives that core's interrupt line.

Each requester has its own simple register port, with a write strobe, a read strobe, an address and data. All ports act in the same cycle, so a post from one core and an acknowledge from another can meet on the same doorbell. Each doorbell has two addresses, a post alias and an acknowledge alias, spaced at a 16-byte stride per core. The enable words sit at a 4-byte stride.

Top module: `mbx_doorbell_unit`

## Requirements
- R1: The address map with the default parameters is as follows. The enable word of core c is at 0x00 + 4*c. The post alias of core c is at 0x40 + 16*c. The acknowledge alias of core c is at 0x80 + 16*c.
- R2: A write to a core's post alias ORs the write data into that doorbell at the next clock edge. Bits that were already set stay set.
- R3: While a port's read strobe is high, its read data shows the current doorbell of the addressed core, from either alias, in the same cycle. While the strobe is low, the read data is zero.
- R4: A write to a core's acknowledge alias clears exactly those doorbell bits whose write-data bit is 1. All other bits are left unchanged.
- R5: A write to an enable word loads write-data bit 0 into that core's enable. Reading the word returns the enable in bit 0 and zero in all other bits.
- R6: The interrupt line of core c is high exactly when core c's enable is 1 and its doorbell is non-zero. The line follows the registered state, with no extra delay.
- R7: When one port posts a bit and another port acknowledges the same bit in the same cycle, the bit ends up set.
- R8: When several ports post to the same doorbell in the same cycle, the doorbell gains the union of all their data.
- R9: When several ports write the same enable word in the same cycle, the lowest-numbered port's value is taken.
- R10: Writes to addresses outside the map are ignored. This includes an offset that is not aligned to the start of a word or alias, and core indices that do not exist. Reads from such addresses return zero.
- R11: Reset is synchronous and active low. It clears every doorbell to zero and every enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | NUM_PORTS | Write strobe, one per port |
| rd_en | input | NUM_PORTS | Read strobe, one per port |
| addr | input | NUM_PORTS x ADDR_W | Byte address, one per port |
| wdata | input | NUM_PORTS x DATA_W | Write data, one per port |
| rdata | output | NUM_PORTS x DATA_W | Combinational read data, one per port |
| mbox_irq | output | NUM_CORES | Doorbell interrupt, one per core |

## Verification
The assertions rely on three conditions: reset is held for at least one clock edge before traffic starts, every input is stable and known around each rising edge, and each port presents one address per cycle. The bench meets these conditions in the following way. It holds reset for several cycles. It changes inputs only on the falling edge. It samples read data one nanosecond later, while all write strobes are low, so that no read depends on ordering at an edge. It posts and acknowledges every bit of every doorbell from rotating ports. It also drives deliberate same-cycle collisions and out-of-map addresses.

// File: rtl/mbx_pkg.sv
// Shared types for the doorbell unit: the address decode result.
package mbx_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_CTRL = 2'd1,
        REG_SET  = 2'd2,
        REG_CLR  = 2'd3
    } mbx_region_e;

    typedef struct packed {
        mbx_region_e region;
        logic [7:0]  core;
    } mbx_hit_t;

endpackage

// File: rtl/mbx_addr_decode.sv
// Decodes one port's byte address into a region and a core index.
// Assumes the three windows do not overlap. Any offset that is not on
// a word start (enable) or an alias start (post/acknowledge) decodes to
// REG_NONE, as does any core index of NUM_CORES or above.
module mbx_addr_decode #(
    parameter int              ADDR_W    = 8,
    parameter int              NUM_CORES = 4,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 8'h00,
    parameter logic [ADDR_W-1:0] SET_BASE  = 8'h40,
    parameter logic [ADDR_W-1:0] CLR_BASE  = 8'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output mbx_pkg::mbx_hit_t hit
);
    import mbx_pkg::*;

    localparam int CTRL_STRIDE = 4;
    localparam int BOX_STRIDE  = 16;
    localparam logic [ADDR_W-1:0] CTRL_SPAN = ADDR_W'(CTRL_STRIDE * NUM_CORES);
    localparam logic [ADDR_W-1:0] BOX_SPAN  = ADDR_W'(BOX_STRIDE * NUM_CORES);

    logic [ADDR_W-1:0] off_ctrl, off_set, off_clr;

    // Offsets of the address into each window.
    always_comb begin
        off_ctrl = addr - CTRL_BASE;
        off_set  = addr - SET_BASE;
        off_clr  = addr - CLR_BASE;
    end

    // Region and core selection; exact alignment required.
    always_comb begin
        hit.region = REG_NONE;
        hit.core   = '0;
        if (addr >= CTRL_BASE && off_ctrl < CTRL_SPAN && off_ctrl[1:0] == 2'b00) begin
            hit.region = REG_CTRL;
            hit.core   = 8'(off_ctrl >> 2);
        end else if (addr >= SET_BASE && off_set < BOX_SPAN && off_set[3:0] == 4'h0) begin
            hit.region = REG_SET;
            hit.core   = 8'(off_set >> 4);
        end else if (addr >= CLR_BASE && off_clr < BOX_SPAN && off_clr[3:0] == 4'h0) begin
            hit.region = REG_CLR;
            hit.core   = 8'(off_clr >> 4);
        end
    end

endmodule

// File: rtl/mbx_slot.sv
// One core's doorbell word, its enable and its interrupt line.
// Assumes the set and clear masks are already merged across all ports.
// A bit that is both set and cleared in the same cycle stays set.
module mbx_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic              en_wr,
    input  logic              en_val,
    output logic [DATA_W-1:0] box,
    output logic              en,
    output logic              irq
);

    // Doorbell update: acknowledge first, then post, so a post wins.
    always_ff @(posedge clk) begin
        if (!rst_n) box <= '0;
        else        box <= (box & ~clr_mask) | set_mask;
    end

    // Enable flag load.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= 1'b0;
        else if (en_wr) en <= en_val;
    end

    // Interrupt from registered state.
    assign irq = en & (|box);

    p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (box == '0 && !en));

    p_post_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((box & $past(set_mask)) == $past(set_mask)));

    p_ack_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((box & $past(clr_mask) & ~$past(set_mask)) == '0));

    p_post_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask & clr_mask) != '0) |=> ((box & $past(set_mask & clr_mask)) != '0));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0) |=> $stable(box));

    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en));

endmodule

// File: rtl/mbx_doorbell_unit.sv
// Doorbell unit top. It provides NUM_PORTS requester ports and NUM_CORES
// doorbells. Post and acknowledge masks are merged across ports. The
// lowest-numbered port wins a clash on an enable word. Reads are
// combinational and return zero when the read strobe is low.
module mbx_doorbell_unit #(
    parameter int                NUM_PORTS = 4,
    parameter int                NUM_CORES = 4,
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 8'h00,
    parameter logic [ADDR_W-1:0] SET_BASE  = 8'h40,
    parameter logic [ADDR_W-1:0] CLR_BASE  = 8'h80
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              wr_en,
    input  logic [NUM_PORTS-1:0]              rd_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata,
    output logic [NUM_CORES-1:0]              mbox_irq
);
    import mbx_pkg::*;

    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    mbx_hit_t          hit    [NUM_PORTS];
    logic [DATA_W-1:0] box_q  [NUM_CORES];
    logic              en_q   [NUM_CORES];
    logic [DATA_W-1:0] rd_word[NUM_PORTS];

    // Per-port address decode.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        mbx_addr_decode #(
            .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES),
            .CTRL_BASE(CTRL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
        ) u_dec (
            .addr(addr[p]),
            .hit (hit[p])
        );
    end

    // Per-core mask merge and state.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [DATA_W-1:0] set_m, clr_m;
        logic              en_wr, en_val;

        // Merge posts and acknowledges that target this core.
        always_comb begin
            set_m = '0;
            clr_m = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (wr_en[p] && hit[p].core == 8'(c)) begin
                    if (hit[p].region == REG_SET) set_m = set_m | wdata[p];
                    if (hit[p].region == REG_CLR) clr_m = clr_m | wdata[p];
                end
            end
        end

        // Pick the enable write; the lowest port is visited last and wins.
        always_comb begin
            en_wr  = 1'b0;
            en_val = 1'b0;
            for (int p = NUM_PORTS - 1; p >= 0; p--) begin
                if (wr_en[p] && hit[p].region == REG_CTRL && hit[p].core == 8'(c)) begin
                    en_wr  = 1'b1;
                    en_val = wdata[p][0];
                end
            end
        end

        mbx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_mask(set_m),
            .clr_mask(clr_m),
            .en_wr   (en_wr),
            .en_val  (en_val),
            .box     (box_q[c]),
            .en      (en_q[c]),
            .irq     (mbox_irq[c])
        );

        p_irq_off_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (en_wr && !en_val) |=> !mbox_irq[c]);
    end

    // Per-port read mux.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        // Select the addressed word, or zero.
        always_comb begin
            rd_word[p] = '0;
            if (rd_en[p]) begin
                case (hit[p].region)
                    REG_CTRL: rd_word[p] = DATA_W'(en_q[hit[p].core[IDX_W-1:0]]);
                    REG_SET,
                    REG_CLR:  rd_word[p] = box_q[hit[p].core[IDX_W-1:0]];
                    default:  rd_word[p] = '0;
                endcase
            end
        end
        assign rdata[p] = rd_word[p];
    end

endmodule

// File: tb/mbx_doorbell_unit_test.sv
`timescale 1ns/1ps
module mbx_doorbell_unit_test;
    localparam int NP = 4;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]       wr_en = '0;
    logic [NP-1:0]       rd_en = '0;
    logic [NP-1:0][7:0]  addr  = '0;
    logic [NP-1:0][31:0] wdata = '0;
    logic [NP-1:0][31:0] rdata;
    logic [NC-1:0]       mbox_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_box[NC];
    logic        m_en[NC];

    always #2 clk = ~clk;

    mbx_doorbell_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .mbox_irq(mbox_irq)
    );

    function automatic logic [7:0] a_ctl(int c); return 8'(4 * c); endfunction
    function automatic logic [7:0] a_set(int c); return 8'('h40 + 16 * c); endfunction
    function automatic logic [7:0] a_clr(int c); return 8'('h80 + 16 * c); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(int p, logic [7:0] a, logic [31:0] d);
        wr_en[p] = 1'b1; addr[p] = a; wdata[p] = d;
    endtask

    // Model update from the requirements, then let one edge pass.
    task automatic go();
        for (int c = 0; c < NC; c++) begin
            logic [31:0] s, k;
            s = '0; k = '0;
            for (int p = 0; p < NP; p++) begin
                if (wr_en[p] && addr[p] == a_set(c)) s |= wdata[p];
                if (wr_en[p] && addr[p] == a_clr(c)) k |= wdata[p];
            end
            for (int p = NP - 1; p >= 0; p--)
                if (wr_en[p] && addr[p] == a_ctl(c)) m_en[c] = wdata[p][0];
            m_box[c] = (m_box[c] & ~k) | s;
        end
        @(negedge clk);
        wr_en = '0; addr = '0; wdata = '0;
    endtask

    // Read one core through three ports and check its interrupt.
    task automatic check_core(int c, string req);
        rd_en = 4'b0111;
        addr[0] = a_clr(c); addr[1] = a_set(c); addr[2] = a_ctl(c);
        #1;
        chk({req, " R3 ack alias"}, rdata[0], m_box[c]);
        chk({req, " R3 post alias"}, rdata[1], m_box[c]);
        chk({req, " R5 enable word"}, rdata[2], {31'b0, m_en[c]});
        chk({req, " R6 irq"}, {31'b0, mbox_irq[c]}, {31'b0, m_en[c] & (|m_box[c])});
        rd_en = '0; addr = '0;
        @(negedge clk);
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < NC; c++) check_core(c, req);
    endtask

    initial begin
        #200000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin m_box[c] = '0; m_en[c] = 1'b0; end
        // Load junk before reset to show that reset clears it.
        repeat (2) @(negedge clk);
        put(0, a_set(1), 32'hdead_beef); put(1, a_ctl(2), 32'h1);
        @(negedge clk);
        wr_en = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_all("R11 reset");

        // R1 R2: post every bit of every core, one bit at a time, rotating ports.
        for (int c = 0; c < NC; c++) begin
            put(c, a_ctl(c), 32'h1); go();
            for (int b = 0; b < 32; b++) begin
                put(b % NP, a_set(c), 32'h1 << b); go();
                check_core(c, "R2 R1 post sweep");
            end
        end
        // R4: acknowledge odd bits one at a time, then even bits together.
        for (int c = 0; c < NC; c++) begin
            for (int b = 1; b < 32; b += 2) begin
                put((b + 1) % NP, a_clr(c), 32'h1 << b); go();
                check_core(c, "R4 single ack");
            end
            put(3, a_clr(c), 32'h5555_5555); go();
            check_core(c, "R4 bulk ack");
        end
        // R6: the enable/doorbell matrix on each core.
        for (int c = 0; c < NC; c++) begin
            for (int e = 0; e < 2; e++) begin
                put(0, a_ctl(c), 32'(e)); go();
                check_core(c, "R6 empty");
                put(1, a_set(c), 32'h8000_0001); go();
                check_core(c, "R6 full");
                put(2, a_clr(c), 32'hffff_ffff); go();
                check_core(c, "R6 drained");
            end
        end
        // R7: a post and an acknowledge meet on the same bits.
        put(0, a_set(2), 32'h0000_00ff); go();
        put(0, a_clr(2), 32'h0000_00ff); put(1, a_set(2), 32'h0000_000f); go();
        chk("R7 post wins", m_box[2], 32'h0000_000f);
        check_core(2, "R7 collision");
        // R8: four ports post to one doorbell in the same cycle.
        put(0, a_set(1), 32'h1); put(1, a_set(1), 32'h100);
        put(2, a_set(1), 32'h1_0000); put(3, a_set(1), 32'h100_0000); go();
        chk("R8 union", m_box[1], 32'h0101_0101);
        check_core(1, "R8 union");
        // R9: ports clash on one enable word.
        put(1, a_ctl(3), 32'h1); put(2, a_ctl(3), 32'h0); go();
        check_core(3, "R9 low port sets");
        put(0, a_ctl(3), 32'h0); put(3, a_ctl(3), 32'h1); go();
        check_core(3, "R9 low port clears");
        // R10: out-of-map and misaligned writes change nothing.
        put(0, 8'h44, 32'hffff_ffff); put(1, 8'h10, 32'h1);
        put(2, 8'h02, 32'h1);          put(3, 8'hc0, 32'hffff_ffff); go();
        put(0, 8'h88, 32'hffff_ffff);  put(1, 8'h81, 32'hffff_ffff); go();
        check_all("R10 ignored");
        rd_en = 4'b1111; addr[0] = 8'h44; addr[1] = 8'h10; addr[2] = 8'hc0; addr[3] = 8'h83;
        #1;
        for (int p = 0; p < NP; p++) chk("R10 unmapped read", rdata[p], 32'h0);
        rd_en = '0;
        addr[0] = a_set(1);
        #1;
        chk("R3 strobe low", rdata[0], 32'h0);
        addr = '0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule